// File: doc/BRIEF.md
# Sticky Error Status Unit with Masking

This unit gathers up to 32 error sources into one status register, a mask register and a single master-error line for a downstream interrupt bank. Each source is a level. While a source is high its status bit is set, whatever the mask holds, so software can still read errors that are masked. Software clears status bits by writing ones to them. A bit whose source is still active survives that clear. The master-error line is high while any status bit is set and not masked.

A bit that survives a clear is called stuck. Software recovers from it as follows. It writes the mask to all ones, which drops the master line. It then writes the mask back with the stuck bits added. If some other unmasked bit is still set, the master line rises again, so an edge-sensitive interrupt bank sees a fresh event.

Each bit can also hold one queued event: a new rising edge of the source that arrives while the bit is already set. A clear write then leaves the bit set, now carried by the queued event. A second clear removes it. Bits named by the reserved-bit parameter always read zero in status and one in mask.

Top module: `errst_unit`

## Requirements
- R1: After reset, status_o is all zeros, mask_o is all ones and master_err_o is low.
- R2: When err_src_i[i] is high at a clock edge, status_o[i] reads 1 from the next cycle on, for any mask value, for every non-reserved bit i.
- R3: A status clear write is wr_en_i=1 with wr_sel_i=0. It clears status bit i in the next cycle when wr_data_i[i]=1, the source is low and no event is queued for that bit. Bits written with 0 are left unchanged.
- R4: A status clear write of 1 to bit i while err_src_i[i] is high leaves status_o[i] at 1, because the bit is sticky.
- R5: A rising edge of err_src_i[i] while status bit i is already set, in a cycle with no clear of that bit, queues one event. The next clear of bit i leaves it at 1 and empties the queue. A further clear with the source low leaves it at 0.
- R6: A mask load write is wr_en_i=1 with wr_sel_i=1. It sets mask_o to wr_data_i in the next cycle, with the reserved bits forced to 1.
- R7: master_err_o is high exactly when some bit is 1 in status_o and 0 in mask_o.
- R8: A mask load of all ones drives master_err_o low in the next cycle. A later load that leaves a set status bit unmasked drives it high in the cycle after that load, which is a fresh 0-to-1 edge.
- R9: Reserved status bits (parameter RSVD_MASK, by default bits 31..28) read 0 even while their source is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_src_i | input | 32 | Error source levels, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = status clear, 1 = mask load |
| wr_data_i | input | 32 | Write data (ones to clear for status, new value for mask) |
| status_o | output | 32 | Error status register |
| mask_o | output | 32 | Error mask register |
| master_err_o | output | 1 | Unmasked error indication |

## Verification
The collision that matters is a status clear write landing on the same bit, in the same cycle, as a source rising edge. The bench provokes it twice: once on a bit that was clear, and once on a bit that was set after its source had fallen. In both cases it expects the bit to stay set by the live source and no queued event to survive, so that a following clear with the source low removes the bit. A behavioural model also compares the outputs every clock while mask loads collide with sources that are just setting bits, and the master line must follow the model in each of those cycles.

// File: rtl/errst_pkg.sv
package errst_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } errst_sel_e;
endpackage

// File: rtl/errst_bit.sv
module errst_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic clr_i,
  output logic bit_o
);
  logic src_q, pend_q, rise;

  assign rise = src_i & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o  <= 1'b0;
      pend_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      src_q <= src_i;
      if (clr_i) begin
        bit_o  <= src_i | pend_q;
        pend_q <= 1'b0;
      end else begin
        bit_o  <= bit_o | src_i;
        pend_q <= pend_q | (rise & bit_o);
      end
    end
  end

  assert_src_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i |=> bit_o);
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !src_i && !pend_q |=> !bit_o);
  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && src_i |=> bit_o);
  assert_queued_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && pend_q |=> bit_o && !pend_q);
endmodule

// File: rtl/errst_mask.sv
module errst_mask #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RSVD_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_o <= '1;
    else if (load_i) mask_o <= data_i | RSVD_MASK;
  end

  assert_rsvd_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (mask_o & RSVD_MASK) == RSVD_MASK);
endmodule

// File: rtl/errst_master.sv
module errst_master #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         err_o
);
  assign err_o = |(status_i & ~mask_i);
endmodule

// File: rtl/errst_unit.sv
module errst_unit #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RSVD_MASK = 32'hF000_0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] err_src_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         master_err_o
);
  import errst_pkg::*;

  errst_sel_e   sel;
  logic         clr_wr, mask_wr;
  logic [W-1:0] raw;

  assign sel     = errst_sel_e'(wr_sel_i);
  assign clr_wr  = wr_en_i && (sel == SEL_STATUS);
  assign mask_wr = wr_en_i && (sel == SEL_MASK);

  for (genvar i = 0; i < W; i++) begin : g_bit
    errst_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (err_src_i[i]),
      .clr_i (clr_wr & wr_data_i[i]),
      .bit_o (raw[i])
    );
  end

  // reserved bits always read zero
  assign status_o = raw & ~RSVD_MASK;

  errst_mask #(.W(W), .RSVD_MASK(RSVD_MASK)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(mask_wr),
    .data_i(wr_data_i),
    .mask_o(mask_o)
  );

  errst_master #(.W(W)) u_master (
    .status_i(status_o),
    .mask_i  (mask_o),
    .err_o   (master_err_o)
  );

  assert_mask_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr && (&wr_data_i) |=> !master_err_o);
  assert_rsvd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_src_i & RSVD_MASK) != '0 |=> (status_o & RSVD_MASK) == '0);
  assert_src_unmasked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_src_i & ~mask_o & ~RSVD_MASK) != '0) && !wr_en_i |=> master_err_o);
endmodule

// File: tb/sim_errst_unit.sv
module sim_errst_unit;
  localparam int W = 32;
  localparam logic [W-1:0] RSVD = 32'hF000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] src = '0, data = '0;
  logic we = 1'b0, sel = 1'b0;
  logic [W-1:0] status, mask;
  logic master;

  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  errst_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .err_src_i(src), .wr_en_i(we),
    .wr_sel_i(sel), .wr_data_i(data), .status_o(status), .mask_o(mask),
    .master_err_o(master)
  );

  // behavioural reference
  logic [W-1:0] m_eir, m_emr, m_q, m_prev, clr_v, rise_v;
  assign clr_v  = (we && !sel) ? data : '0;
  assign rise_v = src & ~m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_eir <= '0; m_emr <= '1; m_q <= '0; m_prev <= '0;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (clr_v[i]) begin
          m_eir[i] <= src[i] | m_q[i];
          m_q[i]   <= 1'b0;
        end else begin
          if (src[i]) m_eir[i] <= 1'b1;
          if (rise_v[i] && m_eir[i]) m_q[i] <= 1'b1;
        end
      end
      if (we && sel) m_emr <= data | RSVD;
      m_prev <= src;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [W-1:0] es;
      logic em;
      es = m_eir & ~RSVD;
      em = |(es & ~m_emr);
      n_cmp++;
      if (status !== es || mask !== m_emr || master !== em) begin
        n_bad++;
        $display("FAIL %s model: status=%h/%h mask=%h/%h master=%b/%b (actual/expected)",
                 phase, status, es, mask, m_emr, master, em);
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic s, input logic [W-1:0] d, input logic [W-1:0] sv);
    we = w; sel = s; data = d; src = sv;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic summary;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc_cnt);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    chk("R1 status", status, '0);
    chk("R1 mask", mask, '1);
    chk("R1 master", {31'b0, master}, '0);

    phase = "R2";
    cyc(0, 0, '0, 32'h1);
    cyc(0, 0, '0, '0);
    chk("R2 masked set", status, 32'h1);
    chk("R2 master masked", {31'b0, master}, '0);

    phase = "R6";
    cyc(1, 1, '0, '0);
    chk("R6 mask rsvd", mask, RSVD);
    chk("R7 master high", {31'b0, master}, 32'h1);

    phase = "R3";
    cyc(1, 0, 32'h2, '0);
    chk("R3 zero data keeps", status, 32'h1);
    cyc(1, 0, '1, '0);
    chk("R3 cleared", status, '0);
    chk("R7 master low", {31'b0, master}, '0);

    phase = "R4";
    cyc(0, 0, '0, 32'h8);
    cyc(1, 0, 32'h8, 32'h8);
    chk("R4 sticky", status, 32'h8);

    phase = "R5";
    cyc(0, 0, '0, 32'h28);
    cyc(0, 0, '0, 32'h08);
    cyc(0, 0, '0, 32'h28);
    cyc(0, 0, '0, 32'h08);
    cyc(1, 0, 32'h20, 32'h08);
    chk("R5 queued survives", status & 32'h20, 32'h20);
    cyc(1, 0, 32'h20, 32'h08);
    chk("R5 second clear", status & 32'h20, '0);

    phase = "R8";
    cyc(0, 0, '0, 32'h88);
    cyc(0, 0, '0, 32'h08);
    cyc(1, 1, '1, 32'h08);
    chk("R8 all masked", {31'b0, master}, '0);
    cyc(1, 1, 32'h08, 32'h08);
    chk("R8 fresh edge", {31'b0, master}, 32'h1);
    cyc(1, 1, 32'h88, 32'h08);
    chk("R8 all masked again", {31'b0, master}, '0);

    phase = "R9";
    cyc(1, 1, '0, 32'h4000_0008);
    cyc(0, 0, '0, 32'h4000_0000);
    chk("R9 rsvd zero", status & RSVD, '0);
    cyc(1, 0, '1, '0);
    chk("R3 all clear", status, '0);

    phase = "R5";
    cyc(1, 0, 32'h200, 32'h200);
    chk("R5 clear vs first rise", status, 32'h200);
    cyc(0, 0, '0, '0);
    cyc(1, 0, 32'h200, 32'h200);
    chk("R5 clear vs rise when set", status, 32'h200);
    cyc(0, 0, '0, '0);
    cyc(1, 0, 32'h200, '0);
    chk("R5 no queue after collision", status, '0);

    phase = "R7";
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] rs, rd;
      rs = $urandom() & $urandom();
      rd = (k % 3 == 0) ? '1 : $urandom();
      cyc(($urandom() % 2) == 0, ($urandom() % 2) == 1, rd, rs);
    end
    cyc(1, 0, '1, '0);
    cyc(1, 0, '1, '0);
    chk("R3 flush", status, '0);

    summary();
  end
endmodule